// File: doc/BRIEF.md
# Flash Command Interface State Machine

This block is a synthesizable behavioural model of the command front end of a NOR-style parallel flash. On every clock it samples a bus made of an address, a data word and three active-low strobes: chip select, write enable and output enable. Write cycles are matched against fixed address/data keys that make up the unlock, program, sector-erase and chip-erase sequences. A sequence that is accepted starts a simulated embedded operation. That operation lasts a fixed number of clock cycles, set by a parameter, and then updates a small register array that stands in for the flash cells.

While an operation runs, the busy output is held low. Reads that hit the affected region return a status word instead of array data. Bit 7 is a data-polling bit and bit 6 is a toggle bit. Sectors that are not being erased can still be read and programmed in the meantime. An active-low reset stops any operation or partial sequence and puts the decoder back in read mode. It does not touch the array.

The model gives surrounding logic and firmware a cycle-accurate counterpart for command sequencing and completion polling. It leaves out cell physics, supply lockout and analog timing.

Top module: `flash_cmd_if`

## Requirements
- R1: An active-low reset clears the decoder to read mode and drives busy_n high at once. It also drops any partial sequence and abandons any program or erase that is running, leaving every array word unchanged. After reset, rdata reads 0.
- R2: The program sequence is four write cycles: AAh at 5555h, 55h at 2AAAh, A0h at 5555h, and then the target address with its data. When the operation completes, the word holds old AND data, so programming can only clear bits.
- R3: busy_n goes low on the clock edge that takes the final write of a command. It stays low for exactly PROG_CYCLES cycles for a program, and exactly ERASE_CYCLES cycles for an erase counted from the last accepted erase write.
- R4: The sector-erase sequence is six write cycles: AAh at 5555h, 55h at 2AAAh, 80h at 5555h, AAh at 5555h, 55h at 2AAAh, and then 30h at any address inside the sector. The sector number is address bits [MEM_AW-1:MEM_AW-5], which gives 32 sectors. When the operation completes, every word of that sector reads FFh and no other word changes.
- R5: The chip-erase sequence is the same as R4, except that the final cycle writes 10h to 5555h. When it completes, every array word reads FFh.
- R6: A write that does not match the expected next step of a sequence returns the decoder to read mode. It starts nothing and changes no word.
- R7: A status read returns bit 7 as the complement of bit 7 of the final data: the programmed data for a program, or FFh for an erase. Bits 5 to 0 of a status read are 0.
- R8: Bit 6 of a status read is 0 on the first status read after a command starts and inverts on every further status read. Once the operation completes, reads return array data and bit 6 no longer toggles.
- R9: During an erase, several things hold. Reads of sectors that are not queued return array data and do not advance the toggle bit. A program to a sector that is not queued is applied on the edge of its final write and leaves busy_n low. A program to a queued sector is discarded. A program whose final write falls on the edge where the erase completes takes effect together with the erase.
- R10: A further sector-erase sequence accepted during an erase adds its sector to the queue and restarts the full ERASE_CYCLES count. All queued sectors are erased together.
- R11: While a program runs, every write cycle is ignored, and the decoder is still in read mode afterwards.
- R12: A read cycle is one with chip select and output enable low and write enable high. rdata takes the value of a read cycle on the following clock edge and holds it until the next read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all bus sampling occurs on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the decoder and operation state |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write enable; a write cycle is one cycle with cs_n and we_n low |
| oe_n | input | 1 | Active-low output enable; a read cycle needs cs_n and oe_n low with we_n high |
| addr | input | ADDR_W | Bus address, compared in full against the command keys; the low MEM_AW bits select the word |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data: array word or status word |
| busy_n | output | 1 | Low while a program or erase operation runs |

## Verification
Two events can fall on the same clock edge: the completion of a sector erase and the final write of a program aimed at another sector. The bench makes them coincide by waiting a computed number of cycles after the erase command, so that the fourth program write lands on the last cycle of the erase count. It then checks three things: busy_n is high one cycle later, the erased sector reads FFh, and the programmed word holds the ANDed value. A complete read sweep of the array then compares every word with the bench's own arithmetic model.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    // Decoder position within a command sequence
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_KEY1,
        SQ_KEY2,
        SQ_PGM,
        SQ_ER1,
        SQ_ER2,
        SQ_ER3
    } seq_e;

    // Embedded operation in progress
    typedef enum logic [1:0] {
        OP_NONE,
        OP_PGM,
        OP_ERS
    } op_e;

    localparam logic [15:0] KEY_ADDR_A = 16'h5555;
    localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;
    localparam logic [7:0]  KEY_DATA_A = 8'hAA;
    localparam logic [7:0]  KEY_DATA_B = 8'h55;
    localparam logic [7:0]  CMD_PGM    = 8'hA0;
    localparam logic [7:0]  CMD_ERS    = 8'h80;
    localparam logic [7:0]  CMD_SECT   = 8'h30;
    localparam logic [7:0]  CMD_CHIP   = 8'h10;

endpackage

// File: rtl/flash_cmd_array.sv
module flash_cmd_array #(
    parameter int DATA_W  = 8,
    parameter int MEM_AW  = 7,
    parameter int SECT_AW = 5
) (
    input  logic                      clk,
    input  logic                      pgm_en,
    input  logic [MEM_AW-1:0]         pgm_addr,
    input  logic [DATA_W-1:0]         pgm_data,
    input  logic                      ers_en,
    input  logic [(1<<SECT_AW)-1:0]   ers_mask,
    input  logic [MEM_AW-1:0]         rd_addr,
    output logic [DATA_W-1:0]         rd_data
);
    localparam int DEPTH    = 1 << MEM_AW;
    localparam int SECT_LSB = MEM_AW - SECT_AW;

    // Cell contents persist across reset, as flash cells do
    logic [DATA_W-1:0] mem_q [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        localparam int SI = w >> SECT_LSB;
        always_ff @(posedge clk) begin
            if (ers_en && ers_mask[SI]) begin
                mem_q[w] <= '1;
            end else if (pgm_en && (pgm_addr == MEM_AW'(w))) begin
                mem_q[w] <= mem_q[w] & pgm_data;
            end
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/flash_cmd_timer.sv
module flash_cmd_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load,
    output logic             done
);
    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    assign done = t_q.run && (t_q.cnt == '0);

    always_comb begin
        t_d = t_q;
        if (done) begin
            t_d.run = 1'b0;
        end else if (t_q.run) begin
            t_d.cnt = t_q.cnt - 1'b1;
        end
        if (start) begin
            t_d.run = 1'b1;
            t_d.cnt = load;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 8,
    parameter int MEM_AW       = 7,
    parameter int NUM_SECT     = 32,
    parameter int PROG_CYCLES  = 16,
    parameter int ERASE_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              busy_n
);
    localparam int SECT_AW  = $clog2(NUM_SECT);
    localparam int SECT_LSB = MEM_AW - SECT_AW;
    localparam int MAX_CYC  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    typedef struct packed {
        seq_e                seq;
        op_e                 op;
        logic [NUM_SECT-1:0] mask;
        logic [MEM_AW-1:0]   paddr;
        logic [DATA_W-1:0]   pdata;
        logic                poll;
        logic                tgl;
        logic [DATA_W-1:0]   rdata;
    } state_t;

    state_t s_d, s_q;

    logic                wr_cyc, rd_cyc, st_rd;
    logic                hit_a, hit_b, at_key_a;
    logic [SECT_AW-1:0]  a_sect;
    logic [NUM_SECT-1:0] sect_hot;
    logic [DATA_W-1:0]   stat_word, arr_rd;
    logic                tmr_start, tmr_done;
    logic                pgm_en, ers_en;
    logic [MEM_AW-1:0]   pgm_addr;
    logic [DATA_W-1:0]   pgm_data;
    seq_e                seq_cur;
    op_e                 op_cur;

    assign wr_cyc   = !cs_n && !we_n;
    assign rd_cyc   = !cs_n && !oe_n && we_n;
    assign at_key_a = (addr == ADDR_W'(KEY_ADDR_A));
    assign hit_a    = at_key_a && (wdata == DATA_W'(KEY_DATA_A));
    assign hit_b    = (addr == ADDR_W'(KEY_ADDR_B)) && (wdata == DATA_W'(KEY_DATA_B));
    assign a_sect   = addr[MEM_AW-1:SECT_LSB];
    assign sect_hot = NUM_SECT'(1) << a_sect;
    assign st_rd    = rd_cyc && ((s_q.op == OP_PGM) ||
                                 ((s_q.op == OP_ERS) && s_q.mask[a_sect]));

    always_comb begin
        stat_word    = '0;
        stat_word[7] = s_q.poll;
        stat_word[6] = s_q.tgl;
    end

    always_comb begin
        s_d       = s_q;
        tmr_start = 1'b0;
        pgm_en    = 1'b0;
        pgm_addr  = s_q.paddr;
        pgm_data  = s_q.pdata;
        ers_en    = 1'b0;

        // Read path: status word or array word, registered
        if (rd_cyc) begin
            if (st_rd) begin
                s_d.rdata = stat_word;
                s_d.tgl   = ~s_q.tgl;
            end else begin
                s_d.rdata = arr_rd;
            end
        end

        // Completion of the running embedded operation
        if (tmr_done) begin
            if (s_q.op == OP_PGM) begin
                pgm_en = 1'b1;
            end else if (s_q.op == OP_ERS) begin
                ers_en = 1'b1;
            end
            s_d.op   = OP_NONE;
            s_d.mask = '0;
        end

        // Command decoder; writes are ignored while a program runs
        if (wr_cyc && (s_q.op != OP_PGM)) begin
            s_d.seq = SQ_IDLE;
            unique case (s_q.seq)
                SQ_IDLE: if (hit_a) s_d.seq = SQ_KEY1;
                SQ_KEY1: if (hit_b) s_d.seq = SQ_KEY2;
                SQ_KEY2: begin
                    if (at_key_a && (wdata == DATA_W'(CMD_PGM))) begin
                        s_d.seq = SQ_PGM;
                    end else if (at_key_a && (wdata == DATA_W'(CMD_ERS))) begin
                        s_d.seq = SQ_ER1;
                    end
                end
                SQ_PGM: begin
                    if (s_q.op == OP_NONE) begin
                        s_d.op    = OP_PGM;
                        s_d.paddr = addr[MEM_AW-1:0];
                        s_d.pdata = wdata;
                        s_d.poll  = ~wdata[7];
                        s_d.tgl   = 1'b0;
                        tmr_start = 1'b1;
                    end else if (!s_q.mask[a_sect]) begin
                        pgm_en   = 1'b1;
                        pgm_addr = addr[MEM_AW-1:0];
                        pgm_data = wdata;
                    end
                end
                SQ_ER1: if (hit_a) s_d.seq = SQ_ER2;
                SQ_ER2: if (hit_b) s_d.seq = SQ_ER3;
                SQ_ER3: begin
                    if (wdata == DATA_W'(CMD_SECT)) begin
                        if ((s_q.op == OP_NONE) || tmr_done) begin
                            s_d.mask = sect_hot;
                            s_d.poll = 1'b0;
                            s_d.tgl  = 1'b0;
                        end else begin
                            s_d.mask = s_q.mask | sect_hot;
                        end
                        s_d.op    = OP_ERS;
                        tmr_start = 1'b1;
                    end else if (at_key_a && (wdata == DATA_W'(CMD_CHIP)) &&
                                 ((s_q.op == OP_NONE) || tmr_done)) begin
                        s_d.mask  = '1;
                        s_d.poll  = 1'b0;
                        s_d.tgl   = 1'b0;
                        s_d.op    = OP_ERS;
                        tmr_start = 1'b1;
                    end
                end
                default: s_d.seq = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{seq: SQ_IDLE, op: OP_NONE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    flash_cmd_timer #(
        .CNT_W (CNT_W)
    ) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .load  ((s_d.op == OP_PGM) ? CNT_W'(PROG_CYCLES - 1) : CNT_W'(ERASE_CYCLES - 1)),
        .done  (tmr_done)
    );

    flash_cmd_array #(
        .DATA_W  (DATA_W),
        .MEM_AW  (MEM_AW),
        .SECT_AW (SECT_AW)
    ) i_array (
        .clk      (clk),
        .pgm_en   (pgm_en),
        .pgm_addr (pgm_addr),
        .pgm_data (pgm_data),
        .ers_en   (ers_en),
        .ers_mask (s_q.mask),
        .rd_addr  (addr[MEM_AW-1:0]),
        .rd_data  (arr_rd)
    );

    assign seq_cur = s_q.seq;
    assign op_cur  = s_q.op;
    assign rdata   = s_q.rdata;
    assign busy_n  = (s_q.op == OP_NONE);

endmodule

// File: rtl/flash_cmd_if_chk.sv
module flash_cmd_if_chk
    import flash_cmd_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int PROG_CYCLES  = 16,
    parameter int ERASE_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cyc,
    input  logic              rd_cyc,
    input  logic              st_rd,
    input  logic              busy_n,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] arr_rd,
    input  seq_e              seq_cur,
    input  op_e               op_cur,
    input  logic              tmr_start,
    input  logic              tmr_done
);
    int unsigned run_cnt;

    // Cycles since the latest operation start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= 0;
        end else if (tmr_start) begin
            run_cnt <= 1;
        end else if (op_cur != OP_NONE) begin
            run_cnt <= run_cnt + 1;
        end
    end

    // R1: reset holds the block ready
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_reset_ready_r1: assert (busy_n)
                else $error("busy_n low during reset");
        end
    end

    // R2: last program write starts the operation
    p_pgm_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_cur == SQ_PGM && wr_cyc && op_cur == OP_NONE) |=> !busy_n);

    // R3: operation length from its latest start
    p_op_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_done |-> run_cnt == ((op_cur == OP_PGM) ? PROG_CYCLES : ERASE_CYCLES));

    // R7: low status bits are zero
    p_status_low_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_rd |=> rdata[5:0] == '0);

    // R8: consecutive status reads alternate bit 6
    p_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_rd && $past(st_rd)) |=> rdata[6] != $past(rdata[6]));

    // R8: non-status reads deliver array data
    p_ready_reads_array_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cyc && !st_rd) |=> rdata == $past(arr_rd));

    // R11: writes during a program leave the decoder idle
    p_ignore_in_prog_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_cur == OP_PGM && wr_cyc) |=> seq_cur == SQ_IDLE);

endmodule

bind flash_cmd_if flash_cmd_if_chk #(
    .DATA_W       (DATA_W),
    .PROG_CYCLES  (PROG_CYCLES),
    .ERASE_CYCLES (ERASE_CYCLES)
) i_flash_cmd_if_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_cyc    (wr_cyc),
    .rd_cyc    (rd_cyc),
    .st_rd     (st_rd),
    .busy_n    (busy_n),
    .rdata     (rdata),
    .arr_rd    (arr_rd),
    .seq_cur   (seq_cur),
    .op_cur    (op_cur),
    .tmr_start (tmr_start),
    .tmr_done  (tmr_done)
);

// File: tb/test_flash_cmd_if.sv
`timescale 1ns/1ps
module test_flash_cmd_if;
    localparam int PC    = 16;
    localparam int EC    = 64;
    localparam int DEPTH = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        busy_n;

    int n_chk = 0, n_fail = 0;
    logic [7:0] mdl [DEPTH];

    always #5 clk = ~clk;

    flash_cmd_if #(
        .PROG_CYCLES  (PC),
        .ERASE_CYCLES (EC)
    ) i_flash_cmd_if (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .busy_n(busy_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); cs_n = 0; we_n = 0; addr = a; wdata = d;
        @(negedge clk); cs_n = 1; we_n = 1;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] v);
        @(negedge clk); cs_n = 0; oe_n = 0; addr = a;
        @(negedge clk); cs_n = 1; oe_n = 1; v = rdata;
    endtask

    task automatic unlock();
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55);
    endtask

    task automatic prog(input logic [15:0] a, input logic [7:0] d);
        unlock(); wr(16'h5555, 8'hA0); wr(a, d);
    endtask

    task automatic erase_pre();
        unlock(); wr(16'h5555, 8'h80); unlock();
    endtask

    task automatic serase(input logic [15:0] a);
        erase_pre(); wr(a, 8'h30);
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!busy_n) begin n++; @(negedge clk); end
    endtask

    task automatic sweep(input string req);
        logic [7:0] v;
        for (int i = 0; i < DEPTH; i++) begin
            rd(16'(i), v);
            chk(v == mdl[i], req, v, mdl[i]);
        end
    endtask

    task automatic model_erase(input int s);
        for (int i = 0; i < 4; i++) mdl[s*4+i] = 8'hFF;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v, v2;
        int n;
        repeat (3) @(negedge clk);
        chk(busy_n == 1'b1, "R1 reset busy", busy_n, 1);
        chk(rdata == 8'h00, "R1 reset rdata", rdata, 0);
        rst_n = 1'b1;

        // R5 chip erase
        erase_pre(); wr(16'h5555, 8'h10);
        wait_ready(n);
        chk(n == EC, "R3 erase length", n, EC);
        for (int i = 0; i < DEPTH; i++) mdl[i] = 8'hFF;
        sweep("R5 chip erase");

        // R2 program sweep, then AND on re-program
        for (int i = 0; i < DEPTH; i += 3) begin
            logic [7:0] d;
            d = 8'((i * 29 + 7) & 8'hFF);
            prog(16'(i), d);
            wait_ready(n);
            chk(n == PC, "R3 program length", n, PC);
            mdl[i] = mdl[i] & d;
        end
        for (int i = 0; i < 30; i += 3) begin
            logic [7:0] d;
            d = 8'((i * 53 + 8'h5A) & 8'hFF);
            prog(16'(i), d);
            wait_ready(n);
            mdl[i] = mdl[i] & d;
        end
        sweep("R2 program AND");

        // R7/R8 status polling during a program
        prog(16'h0041, 8'h3C);
        rd(16'h0041, v); chk(v == 8'h80, "R7 poll bit7 complement", v, 8'h80);
        rd(16'h0005, v); chk(v == 8'hC0, "R8 toggle second read", v, 8'hC0);
        rd(16'h0041, v); chk(v == 8'h80, "R8 toggle third read", v, 8'h80);
        wait_ready(n);
        mdl[8'h41] = mdl[8'h41] & 8'h3C;
        rd(16'h0041, v); chk(v == mdl[8'h41], "R8 data after completion", v, mdl[8'h41]);
        rd(16'h0041, v2); chk(v2 == v, "R8 no toggle after completion", v2, v);
        prog(16'h0042, 8'hA5);
        rd(16'h0042, v); chk(v == 8'h00, "R7 poll bit7 for set bit", v, 8'h00);
        rd(16'h0042, v); chk(v == 8'h40, "R8 toggle", v, 8'h40);
        wait_ready(n);
        mdl[8'h42] = mdl[8'h42] & 8'hA5;

        // R12 hold
        rd(16'h0042, v);
        repeat (5) @(negedge clk);
        chk(rdata == v, "R12 rdata holds", rdata, v);
        chk(v == mdl[8'h42], "R12 read value", v, mdl[8'h42]);

        // R6 mismatches
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h54); wr(16'h5555, 8'hA0); wr(16'h0070, 8'h00);
        chk(busy_n == 1'b1, "R6 wrong data no start", busy_n, 1);
        wr(16'h5555, 8'hAA); wr(16'h2AAB, 8'h55); wr(16'h5555, 8'hA0); wr(16'h0070, 8'h00);
        chk(busy_n == 1'b1, "R6 wrong address no start", busy_n, 1);
        erase_pre(); wr(16'h0070, 8'h20);
        chk(busy_n == 1'b1, "R6 wrong erase code", busy_n, 1);
        erase_pre(); wr(16'h0070, 8'h10);
        chk(busy_n == 1'b1, "R6 chip code off key address", busy_n, 1);
        sweep("R6 no change");

        // R4 sector erase
        serase(16'h0016);
        wait_ready(n);
        chk(n == EC, "R3 sector erase length", n, EC);
        model_erase(5);
        sweep("R4 sector erase");

        // R9 concurrency during erase of sector 3
        serase(16'h000D);
        rd(16'h000E, v); chk(v == 8'h00, "R7 erase poll", v, 8'h00);
        rd(16'h001C, v); chk(v == mdl[28], "R9 unqueued read", v, mdl[28]);
        rd(16'h000C, v); chk(v == 8'h40, "R9 unqueued read no toggle", v, 8'h40);
        prog(16'h001D, 8'h0F);
        chk(busy_n == 1'b0, "R9 busy kept during erase", busy_n, 0);
        mdl[29] = mdl[29] & 8'h0F;
        rd(16'h001D, v); chk(v == mdl[29], "R9 immediate program", v, mdl[29]);
        prog(16'h000C, 8'h00);
        wait_ready(n);
        model_erase(3);
        sweep("R9 queued program discarded");

        // R10 append a sector during erase
        serase(16'h0028);
        repeat (20) @(negedge clk);
        chk(busy_n == 1'b0, "R10 busy before append", busy_n, 0);
        serase(16'h002F);
        wait_ready(n);
        chk(n == EC, "R10 restart length", n, EC);
        model_erase(10); model_erase(11);
        sweep("R10 both sectors erased");

        // R9 program landing on the erase completion edge
        serase(16'h0051);
        repeat (EC - 8) @(negedge clk);
        prog(16'h0057, 8'h55);
        chk(busy_n == 1'b1, "R9 erase done with program", busy_n, 1);
        model_erase(20);
        mdl[8'h57] = mdl[8'h57] & 8'h55;
        sweep("R9 coincident program and erase");

        // R11 writes ignored while programming
        prog(16'h0050, 8'h0F);
        prog(16'h0060, 8'h00);
        wait_ready(n);
        mdl[8'h50] = mdl[8'h50] & 8'h0F;
        wr(16'h0060, 8'h00);
        chk(busy_n == 1'b1, "R11 decoder idle after program", busy_n, 1);
        rd(16'h0060, v); chk(v == mdl[8'h60], "R11 ignored program", v, mdl[8'h60]);
        rd(16'h0050, v); chk(v == mdl[8'h50], "R11 first program", v, mdl[8'h50]);

        // R1 reset aborts erase, program and partial sequence
        serase(16'h0008);
        repeat (5) @(negedge clk);
        rst_n = 1'b0; #1;
        chk(busy_n == 1'b1, "R1 abort erase busy", busy_n, 1);
        @(negedge clk); rst_n = 1'b1;
        prog(16'h0009, 8'h00);
        repeat (3) @(negedge clk);
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        chk(busy_n == 1'b1, "R1 abort program busy", busy_n, 1);
        unlock(); wr(16'h5555, 8'hA0);
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        wr(16'h000A, 8'h00);
        chk(busy_n == 1'b1, "R1 partial sequence dropped", busy_n, 1);
        sweep("R1 array untouched by reset");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule